// File: doc/BRIEF.md
# Shared Mailbox Requester Engine

This engine is the requesting side of a 256-bit shared mailbox that is reached through a 32-bit register master port. A single start pulse hands it an operation and its arguments. The operation is either establish or destroy. The arguments are a reset flag, four 64-bit physical addresses of page-aligned queues and an interrupt vector index. The engine first checks the arguments. It then polls the mailbox's control dword until the responder gives up ownership. Next it writes the request, polls again for the reply and judges the reply's header. It finishes with a one-cycle done pulse and an error code.

An establish request carries all four queue addresses in compressed form. Only the page frame numbers are sent. Each frame number is split into a 48-bit low part and a 4-bit high part, so that four of them, the vector and a control header fit in eight dwords. A destroy request sends the control header alone. Every ownership poll has a bounded number of attempts and a fixed idle gap between reads, so a responder that never answers produces a timeout and does not stall the engine.

The register port has a fixed read latency: read data is valid in the cycle after `busRd` is high. Register index 7 is the control dword, and bit 31 of that dword set means the responder owns the mailbox.

Top module: `mbox_requester`

## Requirements
- R1: After reset the engine is idle, with `busy`, `done`, `busWr` and `busRd` all low.
- R2: An establish request is refused with error code 2 (invalid argument) when any address has a nonzero bit below PAGE_SHIFT, or when `vecIdx` has a nonzero bit above bit 15. A refused request causes no bus read and no bus write. A destroy request never checks its addresses or its vector.
- R3: In an establish request, frame number = address >> PAGE_SHIFT. The low 48 bits of the frame numbers go to payload bits 47:0 (EQ), 95:48 (CQ), 143:96 (RQ) and 191:144 (SQ). Frame bits 51:48 go to payload bits 195:192 (EQ), 199:196 (CQ), 203:200 (RQ) and 207:204 (SQ). The vector goes to bits 223:208. Dword n is payload bits 32n+31:32n.
- R4: The request header in dword 7 has the message type in bits 2:0 (1 = establish, 2 = destroy) and the reset flag in bit 24. All other header bits are zero: version in bits 5:3, direction in bit 7, status in bits 15:8 and the ownership flag in bit 31.
- R5: An establish request writes dwords 0 to 7 once each, in ascending order. A destroy request writes only dword 7. No write happens before a read of dword 7 has returned bit 31 clear.
- R6: Each ownership poll reads dword 7 at most POLL_LIMIT times. Between two reads of one poll there are at least POLL_GAP idle cycles. If no read returns bit 31 clear, the engine ends with error code 1 (timeout). The poll before the write treats 0xFFFFFFFF as owned.
- R7: If the reset flag is set and the reply poll reads 0xFFFFFFFF, the engine ends with code 0. If the reset flag is clear, the same value counts as still owned.
- R8: A reply read with bit 31 clear is accepted only when all three of these hold: type (bits 2:0) equals the request type, version (bits 5:3) is not greater than 0, and direction (bit 7) is 1. Any other reply ends with error code 3 (protocol error).
- R9: An accepted reply with a nonzero status byte (bits 15:8) ends with error code 4 (operation failed). An accepted reply with a zero status byte ends with code 0.
- R10: `done` is high for exactly one cycle per operation, with `errCode` valid in that cycle. A `start` pulse that arrives while `busy` is high is ignored, and so are the arguments that come with it.
- R11: `busRd` and `busWr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| opDestroy | input | 1 | 0 = establish, 1 = destroy |
| resetReq | input | 1 | Reset flag copied into the header |
| eqAddr | input | 64 | Event queue physical address |
| cqAddr | input | 64 | Completion queue physical address |
| rqAddr | input | 64 | Receive queue physical address |
| sqAddr | input | 64 | Send queue physical address |
| vecIdx | input | 32 | Event queue interrupt vector index |
| busWr | output | 1 | Register write strobe |
| busRd | output | 1 | Register read strobe |
| busAddr | output | 3 | Dword index in the mailbox |
| busWdata | output | 32 | Write data |
| busRdata | input | 32 | Read data, valid the cycle after busRd |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 3 | 0 ok, 1 timeout, 2 invalid argument, 3 protocol, 4 operation failed |

## Verification
Several properties are checked on every cycle: the one-cycle done pulse with an in-range code, a poll attempt count that stays under its limit, no write after the header write, exclusive read and write strobes, and latched arguments that change only when an operation is taken. The scenarios show what no single-cycle property can. They cover the exact dword contents and write order of each request kind, and the refusal of bad arguments without bus traffic. They also cover the timeout after exactly POLL_LIMIT reads, the spacing between poll reads, the handling of the all-ones reset pattern with and without the reset flag, and the reply decoding into protocol and operation errors, including a reply whose version is one above the request's.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int DWORDS   = 8;
  localparam int IDX_W    = $clog2(DWORDS);
  localparam int LOW_W    = 48;
  localparam int HIGH_W   = 4;
  localparam int PAYLOAD_W = DWORDS * 32;

  typedef enum logic [2:0] {
    ERR_OK      = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_ARG     = 3'd2,
    ERR_PROTO   = 3'd3,
    ERR_OPFAIL  = 3'd4
  } errCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture arguments
    logic idxLoad;  // set first dword index for the write phase
    logic idxInc;   // advance dword index
    logic rdReq;    // read control dword
    logic wrReq;    // write current dword
  } strobes_t;

  // status from datapath to control
  typedef struct packed {
    logic argOk;
    logic isDestroy;
    logic resetFlag;
    logic lastWord;
    logic rspFree;
    logic rspResetPat;
    logic rspHdrOk;
    logic rspStatusOk;
  } dpStatus_t;
endpackage

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic             opDestroy,
  input  logic             resetReq,
  input  logic [63:0]      eqAddr,
  input  logic [63:0]      cqAddr,
  input  logic [63:0]      rqAddr,
  input  logic [63:0]      sqAddr,
  input  logic [31:0]      vecIdx,
  input  logic [31:0]      busRdata,
  output logic [IDX_W-1:0] busAddr,
  output logic [31:0]      busWdata,
  output dpStatus_t        stat
);
  localparam logic [IDX_W-1:0] HDR_IDX = IDX_W'(DWORDS - 1);

  logic [63:0] addrReg [4];
  logic [15:0] vecReg;
  logic        vecHighBad;
  logic        destroyReg;
  logic        resetReg;
  logic [IDX_W-1:0] wordIdx;

  logic [63:0]          frame [4];
  logic [4*LOW_W-1:0]   lowFields;
  logic [4*HIGH_W-1:0]  highFields;
  logic [3:0]           aligned;
  logic [2:0]           reqType;
  logic [31:0]          hdrWord;
  logic [PAYLOAD_W-1:0] payload;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) addrReg[i] <= '0;
      vecReg     <= '0;
      vecHighBad <= 1'b0;
      destroyReg <= 1'b0;
      resetReg   <= 1'b0;
    end else if (strb.load) begin
      addrReg[0] <= eqAddr;
      addrReg[1] <= cqAddr;
      addrReg[2] <= rqAddr;
      addrReg[3] <= sqAddr;
      vecReg     <= vecIdx[15:0];
      vecHighBad <= |vecIdx[31:16];
      destroyReg <= opDestroy;
      resetReg   <= resetReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wordIdx <= '0;
    else if (strb.idxLoad) wordIdx <= destroyReg ? HDR_IDX : '0;
    else if (strb.idxInc) wordIdx <= wordIdx + 1'b1;
  end

  // frame numbers and split fields, one lane per queue
  for (genvar q = 0; q < 4; q++) begin : g_lane
    assign frame[q] = addrReg[q] >> PAGE_SHIFT;
    assign lowFields[q*LOW_W +: LOW_W]    = frame[q][LOW_W-1:0];
    assign highFields[q*HIGH_W +: HIGH_W] = frame[q][LOW_W +: HIGH_W];
    assign aligned[q] = (addrReg[q][PAGE_SHIFT-1:0] == '0);
  end

  assign reqType  = destroyReg ? 3'd2 : 3'd1;
  assign hdrWord  = {7'd0, resetReg, 16'd0, 5'd0, reqType};
  assign payload  = {hdrWord, vecReg, highFields, lowFields};
  assign busWdata = payload[wordIdx*32 +: 32];
  assign busAddr  = strb.rdReq ? HDR_IDX : wordIdx;

  assign stat.argOk       = (&aligned) && !vecHighBad;
  assign stat.isDestroy   = destroyReg;
  assign stat.resetFlag   = resetReg;
  assign stat.lastWord    = (wordIdx == HDR_IDX);
  assign stat.rspFree     = !busRdata[31];
  assign stat.rspResetPat = (busRdata == 32'hFFFF_FFFF);
  assign stat.rspHdrOk    = (busRdata[2:0] == reqType) && (busRdata[5:3] <= 3'd0) && busRdata[7];
  assign stat.rspStatusOk = (busRdata[15:8] == 8'd0);

  AST_ARGS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(vecReg) && $stable(destroyReg) && $stable(resetReg)); // R10
  AST_NO_WRITE_PAST_HDR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrReq && wordIdx == HDR_IDX) |=> !strb.wrReq); // R5
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int POLL_LIMIT = 20000,
  parameter int POLL_GAP   = 250000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  dpStatus_t stat,
  output strobes_t  strb,
  output logic      busy,
  output logic      done,
  output logic [2:0] errCode
);
  localparam int PC_W  = $clog2(POLL_LIMIT + 1);
  localparam int GAP_W = $clog2(POLL_GAP + 1);

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_RD, S_WT, S_GAP, S_WRITE} state_e;

  state_e state;
  logic   rspPhase;
  logic [PC_W-1:0]  pollCnt;
  logic [GAP_W-1:0] gapCnt;

  assign strb.load    = (state == S_IDLE) && start;
  assign strb.rdReq   = (state == S_RD);
  assign strb.wrReq   = (state == S_WRITE);
  assign strb.idxInc  = (state == S_WRITE) && !stat.lastWord;
  assign strb.idxLoad = (state == S_WT) && !rspPhase && stat.rspFree;
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rspPhase <= 1'b0;
      pollCnt  <= '0;
      gapCnt   <= '0;
      done     <= 1'b0;
      errCode  <= ERR_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) state <= S_CHECK;
        S_CHECK: begin
          if (!stat.isDestroy && !stat.argOk) begin
            done <= 1'b1; errCode <= ERR_ARG; state <= S_IDLE;
          end else begin
            rspPhase <= 1'b0; pollCnt <= '0; state <= S_RD;
          end
        end
        S_RD: state <= S_WT;
        S_WT: begin
          if (rspPhase && stat.resetFlag && stat.rspResetPat) begin
            done <= 1'b1; errCode <= ERR_OK; state <= S_IDLE;
          end else if (stat.rspFree) begin
            if (!rspPhase) state <= S_WRITE;
            else begin
              done    <= 1'b1;
              errCode <= !stat.rspHdrOk ? ERR_PROTO : (stat.rspStatusOk ? ERR_OK : ERR_OPFAIL);
              state   <= S_IDLE;
            end
          end else if (pollCnt == PC_W'(POLL_LIMIT - 1)) begin
            done <= 1'b1; errCode <= ERR_TIMEOUT; state <= S_IDLE;
          end else begin
            pollCnt <= pollCnt + 1'b1; gapCnt <= '0; state <= S_GAP;
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_W'(POLL_GAP - 1)) state <= S_RD;
          else gapCnt <= gapCnt + 1'b1;
        end
        S_WRITE: if (stat.lastWord) begin
          rspPhase <= 1'b1; pollCnt <= '0; state <= S_RD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R10
  AST_ERR_RANGE: assert property (@(posedge clk) disable iff (!rstN) done |-> errCode <= 3'd4); // R10
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN) pollCnt < PC_W'(POLL_LIMIT)); // R6
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(strb.rdReq && strb.wrReq)); // R11
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R10
endmodule

// File: rtl/mbox_requester.sv
module mbox_requester
  import mbox_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int POLL_LIMIT = 20000,
  parameter int POLL_GAP   = 250000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        opDestroy,
  input  logic        resetReq,
  input  logic [63:0] eqAddr,
  input  logic [63:0] cqAddr,
  input  logic [63:0] rqAddr,
  input  logic [63:0] sqAddr,
  input  logic [31:0] vecIdx,
  output logic        busWr,
  output logic        busRd,
  output logic [2:0]  busAddr,
  output logic [31:0] busWdata,
  input  logic [31:0] busRdata,
  output logic        busy,
  output logic        done,
  output logic [2:0]  errCode
);
  strobes_t  strb;
  dpStatus_t stat;

  mbox_ctrl #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat), .strb(strb),
    .busy(busy), .done(done), .errCode(errCode)
  );

  mbox_datapath #(.PAGE_SHIFT(PAGE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opDestroy(opDestroy), .resetReq(resetReq),
    .eqAddr(eqAddr), .cqAddr(cqAddr), .rqAddr(rqAddr), .sqAddr(sqAddr), .vecIdx(vecIdx),
    .busRdata(busRdata), .busAddr(busAddr), .busWdata(busWdata), .stat(stat)
  );

  assign busWr = strb.wrReq;
  assign busRd = strb.rdReq;
endmodule

// File: tb/mbox_requester_test.sv
`timescale 1ns/1ps
module mbox_requester_test;
  localparam int PS = 12, PL = 8, PG = 3;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, opDestroy = 1'b0, resetReq = 1'b0;
  logic [63:0] eqAddr = '0, cqAddr = '0, rqAddr = '0, sqAddr = '0;
  logic [31:0] vecIdx = '0;
  logic busWr, busRd, busy, done;
  logic [2:0] busAddr, errCode;
  logic [31:0] busWdata, busRdata;

  int checks = 0, fails = 0;

  mbox_requester #(.PAGE_SHIFT(PS), .POLL_LIMIT(PL), .POLL_GAP(PG)) uut (
    .clk(clk), .rstN(rstN), .start(start), .opDestroy(opDestroy), .resetReq(resetReq),
    .eqAddr(eqAddr), .cqAddr(cqAddr), .rqAddr(rqAddr), .sqAddr(sqAddr), .vecIdx(vecIdx),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busy(busy), .done(done), .errCode(errCode)
  );

  always #2 clk = ~clk;

  // mailbox model
  logic clrLog = 1'b0;
  int cfgPreBusy = 0, cfgPostBusy = 0;
  logic [31:0] cfgRsp = 32'h0;
  logic [31:0] rdReg;
  logic [2:0]  wrA [16];
  logic [31:0] wrD [16];
  int wrCnt, preRd, postRd, doneCnt, cyc, lastRd, minGap, bothCnt;
  logic gotHdr;
  assign busRdata = rdReg;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) doneCnt <= doneCnt + 1;
    if (busRd && busWr) bothCnt <= bothCnt + 1;
    if (clrLog) begin
      wrCnt <= 0; preRd <= 0; postRd <= 0; gotHdr <= 1'b0; lastRd <= -1; minGap <= 1000;
      rdReg <= 32'h0;
    end else begin
      if (busWr) begin
        if (wrCnt < 16) begin wrA[wrCnt] <= busAddr; wrD[wrCnt] <= busWdata; end
        wrCnt <= wrCnt + 1;
        if (busAddr == 3'd7) gotHdr <= 1'b1;
      end
      if (busRd) begin
        if (lastRd >= 0 && (cyc - lastRd) < minGap) minGap <= cyc - lastRd;
        lastRd <= cyc;
        if (!gotHdr) begin
          rdReg <= (preRd < cfgPreBusy) ? 32'h8000_0000 : 32'h0;
          preRd <= preRd + 1;
        end else begin
          rdReg <= (postRd < cfgPostBusy) ? 32'h8000_0000 : cfgRsp;
          postRd <= postRd + 1;
          lastRd <= (postRd == 0) ? -1 : cyc;
        end
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] packExp(input logic [63:0] a0, a1, a2, a3,
                                           input logic [15:0] v, input logic [31:0] h);
    logic [255:0] p = '0;
    logic [63:0] f [4];
    f[0] = a0 >> PS; f[1] = a1 >> PS; f[2] = a2 >> PS; f[3] = a3 >> PS;
    for (int q = 0; q < 4; q++) begin
      p[q*48 +: 48]     = f[q][47:0];
      p[192 + q*4 +: 4] = f[q][51:48];
    end
    p[223:208] = v;
    p[255:224] = h;
    return p;
  endfunction

  // run one operation; returns error code captured on the done pulse
  task automatic runOp(input logic dst, input logic rst, input int pre, input int post,
                       input logic [31:0] rsp, input logic extraStart, output logic [2:0] err);
    int t = 0;
    cfgPreBusy = pre; cfgPostBusy = post; cfgRsp = rsp;
    @(negedge clk); clrLog = 1'b1;
    @(negedge clk); clrLog = 1'b0;
    opDestroy = dst; resetReq = rst; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (extraStart) begin
      @(negedge clk); @(negedge clk);
      opDestroy = ~dst; start = 1'b1;
      @(negedge clk); start = 1'b0; opDestroy = dst;
    end
    while (!done && t < 2000) begin @(negedge clk); t++; end
    err = errCode;
    @(negedge clk);
  endtask

  task automatic setArgs(input logic [63:0] a0, a1, a2, a3, input logic [31:0] v);
    eqAddr = a0; cqAddr = a1; rqAddr = a2; sqAddr = a3; vecIdx = v;
  endtask

  localparam logic [63:0] A0 = 64'h000F_2345_6789_A000, A1 = 64'h000A_BCDE_F012_3000,
                          A2 = 64'h0005_0000_0000_1000, A3 = 64'h000C_FFFF_FFFF_F000;

  task automatic tReset();
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 busWr", busWr, 0); check("R1 busRd", busRd, 0);
  endtask

  task automatic tEstablish();
    logic [2:0] e; logic [255:0] p;
    setArgs(A0, A1, A2, A3, 32'h0000_BEEF);
    runOp(1'b0, 1'b1, 2, 1, 32'h0000_0081, 1'b0, e);
    p = packExp(A0, A1, A2, A3, 16'hBEEF, 32'h0100_0001);
    check("R9 establish ok", e, 0);
    check("R5 establish write count", wrCnt, 8);
    for (int i = 0; i < 8; i++) begin
      check("R5 write order", wrA[i], i);
      if (i < 7) check("R3 packed dword", wrD[i], p[i*32 +: 32]);
      else check("R4 establish header", wrD[i], p[i*32 +: 32]);
    end
    check("R6 poll gap", minGap, PG + 2);
    check("R10 single done", doneCnt > 0, 1);
  endtask

  task automatic tBadArgs();
    logic [2:0] e;
    setArgs(A0, A1 | 64'h800, A2, A3, 32'h1);
    runOp(1'b0, 1'b0, 0, 0, 32'h81, 1'b0, e);
    check("R2 misaligned", e, 2);
    check("R2 no writes", wrCnt, 0); check("R2 no reads", preRd, 0);
    setArgs(A0, A1, A2, A3, 32'h0001_0000);
    runOp(1'b0, 1'b0, 0, 0, 32'h81, 1'b0, e);
    check("R2 wide vector", e, 2);
    check("R2 no writes vec", wrCnt, 0);
  endtask

  task automatic tDestroy();
    logic [2:0] e;
    setArgs(64'h123, 64'h7, 64'h1, 64'h3, 32'hFFFF_FFFF);
    runOp(1'b1, 1'b0, 0, 2, 32'h0000_0082, 1'b0, e);
    check("R2 destroy ignores args", e, 0);
    check("R5 destroy one write", wrCnt, 1);
    check("R5 destroy addr", wrA[0], 7);
    check("R4 destroy header", wrD[0], 32'h0000_0002);
  endtask

  task automatic tTimeout();
    logic [2:0] e;
    setArgs(A0, A1, A2, A3, 32'h5);
    runOp(1'b0, 1'b0, 100, 0, 32'h81, 1'b0, e);
    check("R6 timeout code", e, 1);
    check("R6 read count", preRd, PL);
    check("R5 no write before ownership", wrCnt, 0);
  endtask

  task automatic tResetPattern();
    logic [2:0] e;
    runOp(1'b1, 1'b1, 0, 0, 32'hFFFF_FFFF, 1'b0, e);
    check("R7 reset pattern with flag", e, 0);
    check("R7 one reply read", postRd, 1);
    runOp(1'b1, 1'b0, 0, 0, 32'hFFFF_FFFF, 1'b0, e);
    check("R7 reset pattern without flag", e, 1);
    check("R7 reply reads", postRd, PL);
  endtask

  task automatic tReplies();
    logic [2:0] e;
    runOp(1'b1, 1'b0, 0, 0, 32'h0000_0081, 1'b0, e);
    check("R8 wrong type", e, 3);
    runOp(1'b1, 1'b0, 0, 0, 32'h0000_008A, 1'b0, e);
    check("R8 newer version", e, 3);
    runOp(1'b1, 1'b0, 0, 0, 32'h0000_0002, 1'b0, e);
    check("R8 direction zero", e, 3);
    runOp(1'b1, 1'b0, 0, 0, 32'h0000_0582, 1'b0, e);
    check("R9 status nonzero", e, 4);
    runOp(1'b1, 1'b0, 0, 0, 32'h00FF_0582, 1'b0, e);
    check("R9 status with reserved", e, 4);
  endtask

  task automatic tBusyStart();
    logic [2:0] e; int d0;
    setArgs(A0, A1, A2, A3, 32'h7);
    d0 = doneCnt;
    runOp(1'b0, 1'b0, 1, 1, 32'h0000_0081, 1'b1, e);
    repeat (12) @(negedge clk);
    check("R10 start ignored code", e, 0);
    check("R10 one done", doneCnt - d0, 1);
    check("R10 write count", wrCnt, 8);
    check("R10 idle after", busy, 0);
    check("R11 no overlap", bothCnt, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    doneCnt = 0; bothCnt = 0;
    tReset();
    tEstablish();
    tBadArgs();
    tDestroy();
    tTimeout();
    tResetPattern();
    tReplies();
    tBusyStart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule